// File: doc/BRIEF.md
# Jitter-Tolerant FSK Modem Character Receiver

This block recovers asynchronous characters from the receive-data line of a 1200-baud FSK modem. The demodulated data carries heavy edge jitter, and the far-end device may run on a skewed time base. The receiver oversamples the line at sixteen ticks per bit cell, derived from the system clock by a programmable divider. It anchors all bit timing to the falling edge that opens each character. It settles every bit with a two-of-three vote over samples packed tightly around the cell centre, so a bit boundary can wander a long way from its ideal place without corrupting the decision.

Each character carries eleven cells: a low start cell, eight data cells sent least significant bit first, an even-parity cell and a high stop cell. A good character produces a one-cycle valid strobe together with the byte and a parity-error flag, and these hold until the next good character. A low stop cell produces a one-cycle framing-error pulse instead. A carrier-detect input gates the whole receiver. While it is low the line is ignored, and if it falls mid-character the character is dropped silently.

Top module: `modem_uart_rx`

## Requirements
- R1: While reset is high and after it is released with the line idle high, `valid_o`, `frm_err_o`, `par_err_o` are 0 and `byte_o` is 0x00.
- R2: A character (start 0, data bits 0..7 in that order, parity bit, stop 1) with correct even parity yields exactly one `valid_o` pulse, with `byte_o` equal to the data and `par_err_o` 0. Even parity means the parity bit equals the XOR of the eight data bits.
- R3: The `valid_o` pulse falls inside the stop cell. It comes between 10 bit times + 9 ticks and 10 bit times + 10 ticks + 8 clocks after the start edge reaches `rxd_i`.
- R4: Each bit is the majority of samples taken at ticks 7, 8 and 9 of its cell, counted from the start edge. A character is received correctly when every later boundary is displaced by up to 20 clocks either way at random, or by 28 clocks (44% of a 64-clock bit) all in the same direction.
- R5: A character sent at a bit rate about 3% fast or 3% slow is received correctly.
- R6: A parity cell that breaks even parity still yields `valid_o` with the received byte, and `par_err_o` is 1. `byte_o` and `par_err_o` change only on a `valid_o` pulse.
- R7: A stop cell that votes low yields one `frm_err_o` pulse and no `valid_o`, and `byte_o` keeps its value. No new character is searched for until the line has been seen high again.
- R8: A low pulse on an idle line that is shorter than half a bit cell (the mid-start vote reads high) produces no `valid_o` and no `frm_err_o`. The next proper character is received correctly.
- R9: While `cd_i` is low, characters on `rxd_i` produce neither `valid_o` nor `frm_err_o`, and `byte_o` is unchanged.
- R10: If `cd_i` falls during a character, that character yields neither `valid_o` nor `frm_err_o`. Reception resumes normally once `cd_i` is high again.
- R11: `valid_o` never lasts more than one cycle and never coincides with `frm_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| rxd_i | input | 1 | Demodulated serial data, idle high, asynchronous |
| cd_i | input | 1 | Carrier detect, high when a usable signal is present, asynchronous |
| byte_o | output | 8 | Last good received byte |
| valid_o | output | 1 | One-cycle strobe for a good character |
| par_err_o | output | 1 | Parity mismatch of the character last strobed |
| frm_err_o | output | 1 | One-cycle pulse when a stop cell votes low |
| | | | |

## Verification
A start edge reaches the decision logic through a two-stage synchroniser and the next tick of the free-running divider. The stop-cell result then follows the tick-9 vote by two registers. Both the valid strobe and the framing pulse are therefore due about 10.6 bit times after the edge is driven, with an uncertainty of one tick plus a few clocks. The bench drives each start edge on a falling clock edge and records its cycle. It captures every strobe on a falling edge into counters and holding variables. It checks counts, byte, flags and strobe cycle only after two further idle bit times have passed, well beyond the due window. The strobe cycle is compared against the R3 window. Stimulus that must have no effect is judged by unchanged strobe counters and an unchanged `byte_o` at that same late point.

// File: rtl/mrx_pkg.sv
package mrx_pkg;

    parameter int unsigned MRX_DATA_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP   = 3'd4
    } mrx_state_e;

    typedef struct packed {
        logic                  valid;
        logic                  frm_err;
        logic                  par_err;
        logic [MRX_DATA_W-1:0] data;
    } mrx_result_t;

    function automatic logic mrx_maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic mrx_even_par(input logic [MRX_DATA_W-1:0] d);
        return ^d;
    endfunction

endpackage

// File: rtl/mrx_sync.sv
module mrx_sync #(
    parameter int unsigned STAGES  = 2,
    parameter bit          RST_VAL = 1'b0
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk_i) begin
        if (rst_i) chain <= {STAGES{RST_VAL}};
        else       chain <= {chain[STAGES-2:0], d_i};
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/mrx_tick_gen.sv
module mrx_tick_gen #(
    parameter int unsigned CLK_DIV = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic tick_o
);
    generate
        if (CLK_DIV <= 1) begin : g_every_clock
            assign tick_o = 1'b1;
        end else begin : g_divider
            localparam int unsigned CW = $clog2(CLK_DIV);
            logic [CW-1:0] cnt;

            always_ff @(posedge clk_i) begin
                if (rst_i)                          cnt <= '0;
                else if (cnt == CW'(CLK_DIV - 1))   cnt <= '0;
                else                                cnt <= cnt + 1'b1;
            end

            assign tick_o = (cnt == CW'(CLK_DIV - 1));

            AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (rst_i)
                tick_o |=> !tick_o); // R4
        end
    endgenerate
endmodule

// File: rtl/mrx_bit_voter.sv
module mrx_bit_voter
    import mrx_pkg::*;
#(
    parameter int unsigned OSR = 16
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic                   tick_i,
    input  logic                   active_i,
    input  logic [$clog2(OSR)-1:0] phase_i,
    input  logic                   rx_i,
    output logic                   vote_o,
    output logic                   ready_o
);
    localparam int unsigned PW  = $clog2(OSR);
    localparam int unsigned MID = OSR / 2;

    logic s_early;
    logic s_mid;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s_early <= 1'b0;
            s_mid   <= 1'b0;
            vote_o  <= 1'b0;
            ready_o <= 1'b0;
        end else begin
            ready_o <= 1'b0;
            if (active_i && tick_i) begin
                if (phase_i == PW'(MID - 1)) s_early <= rx_i;
                if (phase_i == PW'(MID))     s_mid   <= rx_i;
                if (phase_i == PW'(MID + 1)) begin
                    vote_o  <= mrx_maj3(s_early, s_mid, rx_i);
                    ready_o <= 1'b1;
                end
            end
        end
    end

    AST_VOTE_ON_TICK: assert property (@(posedge clk_i) disable iff (rst_i)
        ready_o |-> $past(tick_i && active_i)); // R4
    AST_VOTE_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        ready_o |=> !ready_o); // R4
endmodule

// File: rtl/mrx_frame_fsm.sv
module mrx_frame_fsm
    import mrx_pkg::*;
#(
    parameter int unsigned OSR = 16
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic                   tick_i,
    input  logic                   rx_i,
    input  logic                   cd_i,
    input  logic                   vote_i,
    input  logic                   vote_ready_i,
    output logic                   active_o,
    output logic [$clog2(OSR)-1:0] phase_o,
    output mrx_result_t            result_o
);
    localparam int unsigned PW = $clog2(OSR);
    localparam int unsigned BW = $clog2(MRX_DATA_W);

    mrx_state_e            state;
    logic [PW-1:0]         phase;
    logic [BW-1:0]         bit_cnt;
    logic [MRX_DATA_W-1:0] shreg;
    logic                  par_bit;
    logic                  line_high;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state     <= ST_IDLE;
            phase     <= '0;
            bit_cnt   <= '0;
            shreg     <= '0;
            par_bit   <= 1'b0;
            line_high <= 1'b0;
            result_o  <= '0;
        end else begin
            result_o.valid   <= 1'b0;
            result_o.frm_err <= 1'b0;

            if (tick_i) begin
                line_high <= rx_i;
                if (state != ST_IDLE) begin
                    if (phase == PW'(OSR - 1)) phase <= '0;
                    else                       phase <= phase + 1'b1;
                end
            end

            if (!cd_i) begin
                state <= ST_IDLE;
            end else begin
                case (state)
                    ST_IDLE: begin
                        if (tick_i && line_high && !rx_i) begin
                            state <= ST_START;
                            phase <= PW'(1);
                        end
                    end
                    ST_START: begin
                        if (vote_ready_i) begin
                            if (vote_i) begin
                                state <= ST_IDLE;
                            end else begin
                                state   <= ST_DATA;
                                bit_cnt <= '0;
                            end
                        end
                    end
                    ST_DATA: begin
                        if (vote_ready_i) begin
                            shreg <= {vote_i, shreg[MRX_DATA_W-1:1]};
                            if (bit_cnt == BW'(MRX_DATA_W - 1)) state <= ST_PARITY;
                            else                               bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    ST_PARITY: begin
                        if (vote_ready_i) begin
                            par_bit <= vote_i;
                            state   <= ST_STOP;
                        end
                    end
                    ST_STOP: begin
                        if (vote_ready_i) begin
                            if (vote_i) begin
                                result_o.valid   <= 1'b1;
                                result_o.data    <= shreg;
                                result_o.par_err <= mrx_even_par(shreg) ^ par_bit;
                            end else begin
                                result_o.frm_err <= 1'b1;
                            end
                            state <= ST_IDLE;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign active_o = (state != ST_IDLE);
    assign phase_o  = phase;

    AST_CD_FORCES_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
        !cd_i |=> (state == ST_IDLE)); // R9
    AST_ABORT_SILENT: assert property (@(posedge clk_i) disable iff (rst_i)
        (state != ST_IDLE && !cd_i) |=> !(result_o.valid || result_o.frm_err)); // R10
    AST_GLITCH_DROP: assert property (@(posedge clk_i) disable iff (rst_i)
        (state == ST_START && vote_ready_i && vote_i) |=> (state == ST_IDLE && !result_o.valid)); // R8
    AST_RESULT_FROM_STOP: assert property (@(posedge clk_i) disable iff (rst_i)
        (result_o.valid || result_o.frm_err) |-> $past(state == ST_STOP && vote_ready_i)); // R3
endmodule

// File: rtl/modem_uart_rx.sv
module modem_uart_rx
    import mrx_pkg::*;
#(
    parameter int unsigned CLK_DIV     = 4,
    parameter int unsigned OSR         = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic                  rxd_i,
    input  logic                  cd_i,
    output logic [MRX_DATA_W-1:0] byte_o,
    output logic                  valid_o,
    output logic                  par_err_o,
    output logic                  frm_err_o
);
    localparam int unsigned PW = $clog2(OSR);

    logic          rx_s;
    logic          cd_s;
    logic          tick;
    logic          active;
    logic [PW-1:0] phase;
    logic          vote;
    logic          vote_ready;
    mrx_result_t   result;

    mrx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rx_sync (
        .clk_i (clk_i), .rst_i (rst_i), .d_i (rxd_i), .q_o (rx_s)
    );

    mrx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_cd_sync (
        .clk_i (clk_i), .rst_i (rst_i), .d_i (cd_i), .q_o (cd_s)
    );

    mrx_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
        .clk_i (clk_i), .rst_i (rst_i), .tick_o (tick)
    );

    mrx_bit_voter #(.OSR(OSR)) u_voter (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .tick_i   (tick),
        .active_i (active),
        .phase_i  (phase),
        .rx_i     (rx_s),
        .vote_o   (vote),
        .ready_o  (vote_ready)
    );

    mrx_frame_fsm #(.OSR(OSR)) u_fsm (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .tick_i       (tick),
        .rx_i         (rx_s),
        .cd_i         (cd_s),
        .vote_i       (vote),
        .vote_ready_i (vote_ready),
        .active_o     (active),
        .phase_o      (phase),
        .result_o     (result)
    );

    assign byte_o    = result.data;
    assign valid_o   = result.valid;
    assign par_err_o = result.par_err;
    assign frm_err_o = result.frm_err;

    AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |=> !valid_o); // R11
    AST_VALID_FERR_EXCL: assert property (@(posedge clk_i) disable iff (rst_i)
        !(valid_o && frm_err_o)); // R11
    AST_BYTE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !valid_o |-> $stable(byte_o)); // R7
    AST_PERR_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !valid_o |-> $stable(par_err_o)); // R6
endmodule

// File: tb/modem_uart_rx_tb.sv
module modem_uart_rx_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_DIV    = 4;
    localparam int OSR        = 16;
    localparam int BIT        = CLK_DIV * OSR;
    localparam int WD_LIMIT   = 190000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rxd = 1'b1;
    logic       cd  = 1'b1;
    logic [7:0] byte_o;
    logic       valid_o, par_err_o, frm_err_o;

    always #(CLK_PERIOD / 2) clk = ~clk;

    modem_uart_rx #(.CLK_DIV(CLK_DIV), .OSR(OSR), .SYNC_STAGES(2)) u_dut (
        .clk_i (clk), .rst_i (rst), .rxd_i (rxd), .cd_i (cd),
        .byte_o (byte_o), .valid_o (valid_o), .par_err_o (par_err_o), .frm_err_o (frm_err_o)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int         n_valid = 0, n_ferr = 0, n_both = 0, n_long = 0, strobe_cyc = 0;
    logic       prev_valid = 1'b0;
    logic [7:0] cap_data = 8'h00;
    logic       cap_perr = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (valid_o) begin
                n_valid++;
                strobe_cyc = cyc;
                cap_data   = byte_o;
                cap_perr   = par_err_o;
                if (prev_valid) n_long++;
            end
            if (frm_err_o) n_ferr++;
            if (valid_o && frm_err_o) n_both++;
            prev_valid = valid_o;
        end
    end

    int         n_checks = 0, n_fail = 0;
    logic [7:0] exp_byte = 8'h00;

    task automatic check_eq(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_in(input string req, input int act, input int lo, input int hi);
        n_checks++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    function automatic logic even_par_bit(input logic [7:0] d);
        return ^d;
    endfunction

    function automatic int shift_for(input int mode);
        case (mode)
            1:       return int'($urandom_range(40)) - 20;
            2:       return 28;
            3:       return -28;
            default: return 0;
        endcase
    endfunction

    task automatic idle_bits(input int n);
        rxd = 1'b1;
        repeat (n * BIT) @(negedge clk);
    endtask

    // mode: 0 nominal, 1 random +-20 clocks, 2 all late 28, 3 all early 28
    task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit stop_v,
                              input int blen, input int mode, input int hold_low,
                              input int cd_drop_bit, output int start_cyc);
        logic [10:0] cells;
        int          bnd[12];
        int          total;
        cells[0]    = 1'b0;
        cells[8:1]  = d;
        cells[9]    = even_par_bit(d) ^ bad_par;
        cells[10]   = stop_v;
        bnd[0]      = 0;
        for (int k = 1; k <= 10; k++) bnd[k] = k * blen + shift_for(mode);
        bnd[11]     = 11 * blen;
        total       = bnd[11] + hold_low * blen;
        @(negedge clk);
        start_cyc = cyc;
        for (int c = 0; c < total; c++) begin
            int idx = 0;
            for (int k = 1; k <= 10; k++) if (c >= bnd[k]) idx = k;
            if (c >= bnd[11]) rxd = 1'b0;
            else              rxd = cells[idx];
            if (cd_drop_bit >= 0 && c == cd_drop_bit * blen + blen / 2) cd = 1'b0;
            @(negedge clk);
        end
        rxd = 1'b1;
    endtask

    task automatic rx_good(input logic [7:0] d, input int mode, input int blen,
                           input bit timing, input string req);
        int v0 = n_valid;
        int sc;
        send_frame(d, 1'b0, 1'b1, blen, mode, 0, -1, sc);
        idle_bits(2);
        check_eq(req, n_valid - v0, 1);
        check_eq(req, int'(cap_data), int'(d));
        check_eq(req, int'(cap_perr), 0);
        if (timing)
            check_in("R3 strobe cycle", strobe_cyc - sc,
                     10 * BIT + 9 * CLK_DIV, 10 * BIT + 10 * CLK_DIV + 8);
        exp_byte = d;
    endtask

    initial begin
        int sc, v0, f0;
        void'($urandom(32'd20240));
        repeat (6) @(negedge clk);
        check_eq("R1 valid in reset", int'(valid_o), 0);
        check_eq("R1 byte in reset", int'(byte_o), 0);
        check_eq("R1 ferr in reset", int'(frm_err_o), 0);
        rst = 1'b0;
        idle_bits(2);
        check_eq("R1 valid after reset", n_valid, 0);
        check_eq("R1 perr after reset", int'(par_err_o), 0);
        check_eq("R1 ferr after reset", n_ferr, 0);

        // R2 / R3 directed patterns
        rx_good(8'h00, 0, BIT, 1'b1, "R2 0x00");
        rx_good(8'hFF, 0, BIT, 1'b1, "R2 0xFF");
        rx_good(8'hA5, 0, BIT, 1'b1, "R2 0xA5");
        rx_good(8'h01, 0, BIT, 1'b1, "R2 lsb first 0x01");
        rx_good(8'h80, 0, BIT, 1'b1, "R2 lsb first 0x80");

        // R4 random boundary jitter
        for (int i = 0; i < 40; i++) rx_good(8'($urandom_range(255)), 1, BIT, 1'b1, "R4 random jitter");
        // R4 worst-case uniform displacement
        rx_good(8'h55, 2, BIT, 1'b1, "R4 late 0x55");
        rx_good(8'hAA, 2, BIT, 1'b1, "R4 late 0xAA");
        rx_good(8'h55, 3, BIT, 1'b1, "R4 early 0x55");
        rx_good(8'hAA, 3, BIT, 1'b1, "R4 early 0xAA");

        // R5 rate skew
        rx_good(8'h55, 0, BIT - 2, 1'b0, "R5 fast 0x55");
        rx_good(8'hAA, 0, BIT + 2, 1'b0, "R5 slow 0xAA");
        rx_good(8'hC3, 0, BIT + 2, 1'b0, "R5 slow 0xC3");

        // R6 parity error
        v0 = n_valid;
        send_frame(8'h5A, 1'b1, 1'b1, BIT, 0, 0, -1, sc);
        idle_bits(2);
        check_eq("R6 strobe count", n_valid - v0, 1);
        check_eq("R6 data", int'(cap_data), 8'h5A);
        check_eq("R6 perr flag", int'(cap_perr), 1);
        check_eq("R6 perr held", int'(par_err_o), 1);
        exp_byte = 8'h5A;
        rx_good(8'h5A, 0, BIT, 1'b1, "R6 perr clears");

        // R7 framing error with line held low
        v0 = n_valid; f0 = n_ferr;
        send_frame(8'h3C, 1'b0, 1'b0, BIT, 0, 3, -1, sc);
        idle_bits(2);
        check_eq("R7 ferr count", n_ferr - f0, 1);
        check_eq("R7 no valid", n_valid - v0, 0);
        check_eq("R7 byte kept", int'(byte_o), int'(exp_byte));
        rx_good(8'h96, 0, BIT, 1'b1, "R7 recovery");

        // R8 short glitch
        v0 = n_valid; f0 = n_ferr;
        @(negedge clk);
        rxd = 1'b0;
        repeat (12) @(negedge clk);
        rxd = 1'b1;
        idle_bits(2);
        check_eq("R8 no valid", n_valid - v0, 0);
        check_eq("R8 no ferr", n_ferr - f0, 0);
        check_eq("R8 byte kept", int'(byte_o), int'(exp_byte));
        rx_good(8'h69, 0, BIT, 1'b1, "R8 recovery");

        // R9 carrier absent
        cd = 1'b0;
        repeat (4) @(negedge clk);
        v0 = n_valid; f0 = n_ferr;
        send_frame(8'h33, 1'b0, 1'b1, BIT, 0, 0, -1, sc);
        send_frame(8'h0F, 1'b0, 1'b0, BIT, 0, 1, -1, sc);
        idle_bits(2);
        check_eq("R9 no valid", n_valid - v0, 0);
        check_eq("R9 no ferr", n_ferr - f0, 0);
        check_eq("R9 byte kept", int'(byte_o), int'(exp_byte));
        cd = 1'b1;
        idle_bits(1);

        // R10 carrier lost mid-character
        v0 = n_valid; f0 = n_ferr;
        send_frame(8'hE7, 1'b0, 1'b1, BIT, 0, 0, 5, sc);
        idle_bits(2);
        check_eq("R10 no valid", n_valid - v0, 0);
        check_eq("R10 no ferr", n_ferr - f0, 0);
        check_eq("R10 byte kept", int'(byte_o), int'(exp_byte));
        cd = 1'b1;
        idle_bits(1);
        rx_good(8'h7E, 0, BIT, 1'b1, "R10 recovery");

        // R11 strobe shape over the whole run
        check_eq("R11 valid longer than one cycle", n_long, 0);
        check_eq("R11 valid with ferr", n_both, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        if (cyc == WD_LIMIT) begin
            n_checks++;
            n_fail++;
            $display("FAIL R11 watchdog actual=%0d expected<%0d", cyc, WD_LIMIT);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule